// File: doc/BRIEF.md
# Flash Status Auto-Poll Matcher

This block keeps re-reading the status register of a serial flash until the value it wants shows up. Once started in the polling mode, it sends a status-read request to a command engine and waits for the status word to come back. It then compares that word with a programmed target, but only in the bit positions the mask selects and only in the lanes the length selects. A successful compare sets a sticky match flag, which can raise an interrupt. The block then either stops by itself or waits a programmable number of clock cycles and reads again.

Both exchanges with the command engine use valid/ready. A read request stays valid until the engine accepts it. A response is accepted only while the block waits for one. The engine may apply back-pressure on requests for any number of cycles. It may also delay a response for any number of cycles. At most one request is outstanding at any time. Configuration inputs are sampled live and are expected to stay stable while polling runs. Software stops a run that has no automatic stop by pulsing `abort`.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset, `busy`, `req_valid`, `rsp_ready`, `match_flag` and `irq` are 0. A `start` pulse seen while idle with `func_mode` equal to 2 raises `busy` and `req_valid` one clock later. A `start` pulse with any other mode value leaves the block idle.
- R2: `req_valid` stays high until a cycle with `req_ready` high. After that handshake, `rsp_ready` is high and `req_valid` is low until a response is accepted. Only one request is ever outstanding.
- R3: A response matches when, for every lane b from 0 to `len_m1`, (`rsp_data` byte b XOR `target` byte b) AND `mask` byte b is zero. Lane b is bits 8b+7..8b. Lanes above `len_m1` are ignored. A match sets `match_flag` one clock after the response handshake.
- R4: `match_flag` stays set until a cycle with `clr_match` high, and it is 0 on the next clock. When a matching response arrives in the same cycle as `clr_match`, the flag stays set.
- R5: `irq` is high exactly when `match_flag` and `irq_en` are both high.
- R6: With `auto_stop` high, a matching response drops `busy` on the next clock, and no further request is issued.
- R7: With `auto_stop` low, polling continues after matches and keeps re-evaluating each response, until `abort`.
- R8: After a response that does not end polling, `req_valid` rises exactly `interval`+1 clocks after the response handshake.
- R9: `abort` ends polling. While a request is pending without `req_ready`, or during the gap, `busy` drops on the next clock. A request that is accepted in the abort cycle, or one that is already outstanding, is drained: `busy` stays high until its response is accepted, and that response never sets the flag.
- R10: A `start` pulse while `busy` is high has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_mode | input | 2 | Functional mode; value 2 selects auto-polling |
| start | input | 1 | Begin polling (pulse) |
| abort | input | 1 | Stop polling (pulse) |
| auto_stop | input | 1 | Stop on first match |
| irq_en | input | 1 | Match interrupt enable |
| clr_match | input | 1 | Clear match flag (write-one pulse) |
| len_m1 | input | 2 | Compared status bytes minus one |
| mask | input | 32 | Compare mask |
| target | input | 32 | Match value |
| interval | input | 16 | Idle clocks between reads, minus one |
| req_valid | output | 1 | Status-read request valid |
| req_ready | input | 1 | Command engine accepts request |
| rsp_valid | input | 1 | Status response valid |
| rsp_ready | output | 1 | Block accepts response |
| rsp_data | input | 32 | Returned status bytes |
| busy | output | 1 | Polling active |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Match interrupt |

## Verification
Every result has a fixed delay. `busy` and `req_valid` respond one clock after `start`. `match_flag` changes one clock after the response handshake or the clear, while `irq` follows the flag in the same cycle. The next request comes `interval`+1 clocks after a response, and `busy` falls one clock after a stopping response or an abort in the gap. The bench keeps a behavioural model that steps on each rising edge from the inputs it drove. On every falling edge it compares all outputs against that model, so each result is checked in the cycle it is due. Directed checks then confirm request counts, the measured gap and the end states of each scenario.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam logic [1:0] MODE_AUTOPOLL = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_AWAIT = 3'd2,
    ST_GAP   = 3'd3,
    ST_DRAIN = 3'd4
  } poll_state_t;
endpackage

// File: rtl/apm_byte_compare.sv
module apm_byte_compare #(
  parameter int BYTES = 4,
  parameter int LEN_W = 2
) (
  input  logic [8*BYTES-1:0] status,
  input  logic [8*BYTES-1:0] mask,
  input  logic [8*BYTES-1:0] target,
  input  logic [LEN_W-1:0]   len_m1,
  output logic               hit
);
  logic [BYTES-1:0] lane_ok;

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      localparam logic [LEN_W:0] LANE_IDX = (LEN_W+1)'(b);
      assign lane_ok[b] = (LANE_IDX > {1'b0, len_m1}) ||
                          (((status[8*b +: 8] ^ target[8*b +: 8]) & mask[8*b +: 8]) == 8'h00);
    end
  endgenerate

  assign hit = &lane_ok;
endmodule

// File: rtl/apm_gap_timer.sv
module apm_gap_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [IVL_W-1:0] interval,
  output logic             expired
);
  localparam logic [IVL_W-1:0] ONE = {{(IVL_W-1){1'b0}}, 1'b1};
  logic [IVL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= interval;
    else if (run && cnt != '0)  cnt <= cnt - ONE;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher
  import apm_pkg::*;
#(
  parameter int STATUS_BYTES = 4,
  parameter int IVL_W        = 16,
  localparam int DATA_W      = 8 * STATUS_BYTES,
  localparam int LEN_W       = (STATUS_BYTES > 1) ? $clog2(STATUS_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        func_mode,
  input  logic              start,
  input  logic              abort,
  input  logic              auto_stop,
  input  logic              irq_en,
  input  logic              clr_match,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] target,
  input  logic [IVL_W-1:0]  interval,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              match_flag,
  output logic              irq
);
  poll_state_t state, nxt;
  logic hit, expired, set_hit, load_gap, draining, in_gap;

  apm_byte_compare #(.BYTES(STATUS_BYTES), .LEN_W(LEN_W)) u_cmp (
    .status (rsp_data),
    .mask   (mask),
    .target (target),
    .len_m1 (len_m1),
    .hit    (hit)
  );

  apm_gap_timer #(.IVL_W(IVL_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_gap),
    .run      (in_gap),
    .interval (interval),
    .expired  (expired)
  );

  always_comb begin
    nxt      = state;
    set_hit  = 1'b0;
    load_gap = 1'b0;
    unique case (state)
      ST_IDLE:  if (start && func_mode == MODE_AUTOPOLL) nxt = ST_ISSUE;
      ST_ISSUE: begin
        if (req_ready)  nxt = abort ? ST_DRAIN : ST_AWAIT;
        else if (abort) nxt = ST_IDLE;
      end
      ST_AWAIT: begin
        if (rsp_valid) begin
          if (abort) nxt = ST_IDLE;
          else begin
            set_hit  = hit;
            load_gap = 1'b1;
            nxt      = (hit && auto_stop) ? ST_IDLE : ST_GAP;
          end
        end else if (abort) begin
          nxt = ST_DRAIN;
        end
      end
      ST_GAP: begin
        if (abort)        nxt = ST_IDLE;
        else if (expired) nxt = ST_ISSUE;
      end
      ST_DRAIN: if (rsp_valid) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      match_flag <= 1'b0;
    end else begin
      state <= nxt;
      if (set_hit)        match_flag <= 1'b1;
      else if (clr_match) match_flag <= 1'b0;
    end
  end

  assign draining  = (state == ST_DRAIN);
  assign in_gap    = (state == ST_GAP);
  assign req_valid = (state == ST_ISSUE);
  assign rsp_ready = (state == ST_AWAIT) || draining;
  assign busy      = (state != ST_IDLE);
  assign irq       = match_flag && irq_en;
endmodule

// File: rtl/status_poll_matcher_chk.sv
module status_poll_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] func_mode,
  input logic       start,
  input logic       abort,
  input logic       auto_stop,
  input logic       clr_match,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       busy,
  input logic       match_flag,
  input logic       hit,
  input logic       draining,
  input logic       in_gap
);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && func_mode == 2'd2 && !busy) |=> (busy && req_valid));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !abort) |=> req_valid);

  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !rsp_valid) |=> !req_valid);

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && hit && !abort && !draining) |=> match_flag);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_match) |=> match_flag);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_match && !(rsp_valid && rsp_ready && hit)) |=> !match_flag);

  p_autostop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && hit && auto_stop && !abort && !draining) |=> !busy);

  p_gap_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && in_gap) |=> !busy);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !rsp_valid) |=> busy);
endmodule

bind status_poll_matcher status_poll_matcher_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .func_mode  (func_mode),
  .start      (start),
  .abort      (abort),
  .auto_stop  (auto_stop),
  .clr_match  (clr_match),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .busy       (busy),
  .match_flag (match_flag),
  .hit        (hit),
  .draining   (draining),
  .in_gap     (in_gap)
);

// File: tb/status_poll_matcher_test.sv
`timescale 1ns/1ps
module status_poll_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  func_mode;
  logic        start, abort_i, auto_stop, irq_en, clr_i;
  logic [1:0]  len_m1;
  logic [31:0] mask, target, rsp_data;
  logic [15:0] interval;
  logic        req_ready, rsp_valid;
  logic        req_valid, rsp_ready, busy, match_flag, irq;

  always #2.5 clk = ~clk;

  status_poll_matcher uut (
    .clk(clk), .rst_n(rst_n), .func_mode(func_mode), .start(start), .abort(abort_i),
    .auto_stop(auto_stop), .irq_en(irq_en), .clr_match(clr_i), .len_m1(len_m1),
    .mask(mask), .target(target), .interval(interval), .req_valid(req_valid),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .busy(busy), .match_flag(match_flag), .irq(irq)
  );

  int total = 0, fails = 0;
  int ph = 0, gap = 0, np, cyc = 0, last_rsp = 0, gap_meas = -1;
  bit mflag = 0, s;
  int nreq = 0, nrsp = 0, seen_req = 0, seen_rsp = 0;
  int lat = 1, dly = 0;
  bit pend = 0;
  logic [31:0] dflt = 32'h0;
  logic [31:0] rq[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [31:0] d);
    for (int b = 0; b < 4; b++)
      if (b <= int'(len_m1) && (((d ^ target) >> (8*b)) & (mask >> (8*b)) & 32'hFF) != 0)
        return 1'b0;
    return 1'b1;
  endfunction

  // behavioural reference, stepped on each rising edge from driven inputs
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; gap = 0; mflag = 0;
    end else begin
      s = 0; np = ph;
      case (ph)
        0: if (start && func_mode == 2) np = 1;
        1: if (req_ready) begin np = abort_i ? 4 : 2; nreq++; end
           else if (abort_i) np = 0;
        2: if (rsp_valid) begin
             nrsp++;
             if (abort_i) np = 0;
             else begin
               s = exp_hit(rsp_data);
               last_rsp = cyc;
               if (s && auto_stop) np = 0;
               else begin np = 3; gap = int'(interval); end
             end
           end else if (abort_i) np = 4;
        3: if (abort_i) np = 0;
           else if (gap == 0) begin np = 1; gap_meas = cyc - last_rsp; end
           else gap--;
        4: if (rsp_valid) begin np = 0; nrsp++; end
        default: np = 0;
      endcase
      mflag = s ? 1'b1 : (clr_i ? 1'b0 : mflag);
      ph = np;
    end
  end

  // per-cycle comparison and command-engine responder
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (ph != 0), "R1/R6/R9 busy", busy, ph != 0);
      chk(req_valid == (ph == 1), "R2/R8 req_valid", req_valid, ph == 1);
      chk(rsp_ready == (ph == 2 || ph == 4), "R2 rsp_ready", rsp_ready, ph == 2 || ph == 4);
      chk(match_flag == mflag, "R3/R4 match_flag", match_flag, mflag);
      chk(irq == (mflag && irq_en), "R5 irq", irq, mflag && irq_en);
    end
    if (seen_rsp != nrsp) begin rsp_valid = 1'b0; seen_rsp = nrsp; end
    if (seen_req != nreq) begin pend = 1; dly = lat; seen_req = nreq; end
    if (pend) begin
      if (dly == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = (rq.size() != 0) ? rq.pop_front() : dflt;
        pend = 0;
      end else dly--;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic pulse_start(); start = 1; step(); start = 0; endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) step();
  endtask
  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int n0;
    rst_n = 0; func_mode = 0; start = 0; abort_i = 0; auto_stop = 0; irq_en = 0;
    clr_i = 0; len_m1 = 0; mask = 0; target = 0; interval = 0;
    req_ready = 1; rsp_valid = 0; rsp_data = 0;
    repeat (3) step();
    rst_n = 1; step();
    chk(!busy && !req_valid && !rsp_ready && !match_flag && !irq, "R1 reset state", busy, 0);

    // R1: wrong mode is ignored
    func_mode = 2'd1; pulse_start(); step(); step();
    chk(!busy && !req_valid, "R1 start ignored in mode 1", busy, 0);

    // R6/R8: single lane, auto stop after third read
    func_mode = 2'd2; mask = 32'hFF; target = 32'h03; len_m1 = 0;
    auto_stop = 1; irq_en = 1; interval = 3;
    rq = {32'h01, 32'h07, 32'h03};
    n0 = nreq; pulse_start(); wait_idle();
    chk(nreq - n0 == 3, "R6 reads until match", nreq - n0, 3);
    chk(gap_meas == 4, "R8 gap interval+1", gap_meas, 4);
    chk(match_flag, "R3 flag on match", match_flag, 1);
    chk(irq, "R5 irq when enabled", irq, 1);
    repeat (5) step();
    chk(!busy && nreq - n0 == 3, "R6 no read after stop", nreq - n0, 3);

    // R4/R5: masking and clearing
    irq_en = 0; step();
    chk(!irq, "R5 irq masked", irq, 0);
    clr_i = 1; step(); clr_i = 0; step();
    chk(!match_flag, "R4 clear", match_flag, 0);

    // R3: two lanes, upper lanes ignored
    len_m1 = 2'd1; mask = 32'h0000FF0F; target = 32'h0000A505; interval = 0;
    rq = {32'h0000A405, 32'hFF00A505};
    n0 = nreq; pulse_start(); wait_idle();
    chk(nreq - n0 == 2, "R3 lane1 compared upper ignored", nreq - n0, 2);
    chk(match_flag, "R3 two-lane match", match_flag, 1);
    clr_i = 1; step(); clr_i = 0;

    // R3: four lanes, only lane 3 masked in
    len_m1 = 2'd3; mask = 32'hFF000000; target = 32'h5A000000;
    rq = {32'h4A000000, 32'h5A123456};
    n0 = nreq; pulse_start(); wait_idle();
    chk(nreq - n0 == 2, "R3 lane3 compare", nreq - n0, 2);
    clr_i = 1; step(); clr_i = 0;

    // R7/R2/R10/R4: continuous polling with matches
    auto_stop = 0; interval = 2; dflt = 32'h5A000000;
    n0 = nreq; pulse_start();
    repeat (30) step();
    chk(busy, "R7 keeps polling after match", busy, 1);
    chk(nreq - n0 >= 4, "R7 repeated reads", nreq - n0, 4);
    req_ready = 0;
    for (int i = 0; i < 20 && !req_valid; i++) step();
    repeat (5) step();
    chk(req_valid, "R2 request held under back-pressure", req_valid, 1);
    n0 = nreq; pulse_start(); step();
    chk(busy && req_valid && nreq == n0, "R10 start while busy ignored", nreq - n0, 0);
    req_ready = 1;
    clr_i = 1; repeat (12) step(); clr_i = 0; step();

    // R9: abort during the gap
    interval = 40;
    for (int i = 0; i < 50 && !rsp_ready; i++) step();
    for (int i = 0; i < 50 && rsp_ready; i++) step();
    step();
    abort_i = 1; step(); abort_i = 0;
    chk(!busy, "R9 abort in gap", busy, 0);

    // R9: abort with a read outstanding
    clr_i = 1; step(); clr_i = 0;
    lat = 6; interval = 1;
    pulse_start();
    for (int i = 0; i < 20 && !rsp_ready; i++) step();
    abort_i = 1; step(); abort_i = 0;
    chk(busy, "R9 drain keeps busy", busy, 1);
    wait_idle();
    chk(!match_flag, "R9 drained response ignored", match_flag, 0);

    // R9: abort in the same cycle the request is accepted
    req_ready = 0; pulse_start();
    abort_i = 1; req_ready = 1; step(); abort_i = 0;
    chk(busy && rsp_ready, "R9 accepted request drained", busy, 1);
    wait_idle();
    chk(!busy && !match_flag, "R9 idle after drain", busy, 0);

    repeat (3) step();
    summary();
    $finish;
  end
endmodule